// File: doc/BRIEF.md
# Privileged Control Register File

This block is a small bank of privileged control registers that sits behind one synchronous access port. Software issues an access with an address, a write enable and 64-bit write data. Read data comes back combinationally from the stored values. An error flag marks accesses the bank refuses.

Several writes have side effects. The soft-interrupt register also has two alias addresses: one sets bits and one clears bits. The trap-base register drops its low bits. The hyperprivileged-state register always gets its identification bit set on a write. The version register is read-only and is built from parameters. The bank also holds an interrupt-level register, a processor-state register and eight interrupt queue head/tail registers.

Some writes change state in a way that could make an interrupt deliverable. When that happens the bank raises a one-cycle `recheck` pulse for the downstream interrupt unit. The pulse is registered, so it is high in the cycle that follows the write's clock edge.

Top module: `ctlreg_file`

## Requirements
- R1: After synchronous reset, every mapped register reads zero except the version word, and `recheck` is low.
- R2: A write to address 0 (soft interrupt) stores the low `SOFT_W` bits (default 17) of the data. It pulses `recheck` only if the stored value changes.
- R3: A write to address 1 (set alias) stores the old soft-interrupt value OR the data. It pulses `recheck` only if the value changes. Reads of addresses 1 and 2 return the soft-interrupt value.
- R4: A write to address 2 (clear alias) stores the old soft-interrupt value AND the complement of the data. It pulses `recheck` only if the value changes.
- R5: A write to address 3 (interrupt level) stores the low `PIL_W` bits (default 4). It pulses `recheck` only if the new level is strictly below the current one.
- R6: A write to address 4 (processor state) stores the data. It pulses `recheck` only when bit `IE_BIT` (default 1) goes from 0 to 1.
- R7: Address 5 (trap base) stores the data with bits 14:0 forced to zero, and those bits always read zero. A write to it never pulses `recheck`.
- R8: Address 6 (version) reads the window count in bits 7:0, the maximum trap level in bits 15:8 and the maximum global level in bits 23:16. A write to it sets `err` in that cycle and changes nothing.
- R9: Every write to address 7 (hyperprivileged state) stores the data with bit `ID_BIT` (default 11) forced to 1.
- R10: Addresses 8 to 15 are the eight queue head/tail registers. A write to one stores the full 64-bit value and always pulses `recheck`, even if the value does not change.
- R11: Any access with address bit 4 set is unmapped. It sets `err` in that cycle, reads zero, changes no register and raises no `recheck`.
- R12: `recheck` is high for exactly the one cycle after the edge that performs a qualifying write. It is low after any cycle with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accEn | input | 1 | Access valid this cycle |
| wrEn | input | 1 | Access is a write |
| addr | input | 5 | Register address |
| wrData | input | 64 | Write data |
| rdData | output | 64 | Combinational read data for `addr` |
| err | output | 1 | Access refused (unmapped, or write to version) |
| recheck | output | 1 | One-cycle interrupt recheck pulse |

## Verification
The assertions assume that `addr` and `wrData` are stable for the whole cycle of any access. They also assume `wrEn` is only meaningful while `accEn` is high. The bench keeps to this by changing every input only on the falling clock edge, or just after the rising edge. The bench also ends each write after one cycle, so every `recheck` pulse it sees comes from a single known write. The version constants are kept within eight bits each, so the composed fields cannot overlap.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int ADDR_W = 5;
  localparam int NUM_Q  = 8;

  typedef enum logic [2:0] {
    SEL_SOFT = 3'd0, SEL_SSET = 3'd1, SEL_SCLR = 3'd2, SEL_PIL = 3'd3,
    SEL_PST  = 3'd4, SEL_TBA  = 3'd5, SEL_VER  = 3'd6, SEL_HST = 3'd7
  } base_sel_e;

  typedef struct packed {
    logic             wrSoft;
    logic             wrSet;
    logic             wrClr;
    logic             wrPil;
    logic             wrPst;
    logic             wrTba;
    logic             wrHst;
    logic [NUM_Q-1:0] wrQ;
    logic [3:0]       rdSel;
    logic             rdNone;
  } strobe_t;
endpackage

// File: rtl/ctlreg_ctrl.sv
module ctlreg_ctrl
  import ctlreg_pkg::*;
(
  input  logic              accEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb,
  output logic              err
);
  logic mapped;
  logic isWr;

  assign mapped = !addr[ADDR_W-1];
  assign isWr   = accEn && wrEn && mapped;

  always_comb begin
    stb        = '0;
    stb.rdSel  = addr[3:0];
    stb.rdNone = !mapped;
    if (isWr && !addr[3]) begin
      case (base_sel_e'(addr[2:0]))
        SEL_SOFT: stb.wrSoft = 1'b1;
        SEL_SSET: stb.wrSet  = 1'b1;
        SEL_SCLR: stb.wrClr  = 1'b1;
        SEL_PIL:  stb.wrPil  = 1'b1;
        SEL_PST:  stb.wrPst  = 1'b1;
        SEL_TBA:  stb.wrTba  = 1'b1;
        SEL_HST:  stb.wrHst  = 1'b1;
        default:  ;
      endcase
    end
    for (int i = 0; i < NUM_Q; i++) begin
      stb.wrQ[i] = isWr && addr[3] && (addr[2:0] == 3'(i));
    end
  end

  assign err = accEn && (!mapped ||
               (wrEn && !addr[3] && base_sel_e'(addr[2:0]) == SEL_VER));
endmodule

// File: rtl/ctlreg_dpath.sv
module ctlreg_dpath
  import ctlreg_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SOFT_W  = 17,
  parameter int PIL_W   = 4,
  parameter int IE_BIT  = 1,
  parameter int ID_BIT  = 11,
  parameter int TBA_LOW = 15,
  parameter int WINDOWS = 8,
  parameter int MAX_TL  = 6,
  parameter int MAX_GL  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              recheck
);
  localparam logic [DATA_W-1:0] VER_WORD =
      DATA_W'(WINDOWS & 8'hFF) | (DATA_W'(MAX_TL & 8'hFF) << 8) |
      (DATA_W'(MAX_GL & 8'hFF) << 16);
  localparam logic [DATA_W-1:0] ID_MASK = DATA_W'(1) << ID_BIT;
  localparam int TBA_HI = DATA_W - TBA_LOW;

  logic [SOFT_W-1:0] softQ, softNext;
  logic [PIL_W-1:0]  pilQ;
  logic [DATA_W-1:0] pstQ, hstQ;
  logic [TBA_HI-1:0] tbaQ;
  logic [DATA_W-1:0] qReg [NUM_Q];
  logic              softChg, pilLower, ieRise, qWr, recheckQ;

  always_comb begin
    softNext = softQ;
    if (stb.wrSoft)     softNext = wrData[SOFT_W-1:0];
    else if (stb.wrSet) softNext = softQ | wrData[SOFT_W-1:0];
    else if (stb.wrClr) softNext = softQ & ~wrData[SOFT_W-1:0];
  end

  assign softChg  = softNext != softQ;
  assign pilLower = stb.wrPil && (wrData[PIL_W-1:0] < pilQ);
  assign ieRise   = stb.wrPst && wrData[IE_BIT] && !pstQ[IE_BIT];
  assign qWr      = |stb.wrQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      softQ    <= '0;
      pilQ     <= '0;
      pstQ     <= '0;
      tbaQ     <= '0;
      hstQ     <= '0;
      recheckQ <= 1'b0;
    end else begin
      softQ    <= softNext;
      recheckQ <= softChg || pilLower || ieRise || qWr;
      if (stb.wrPil) pilQ <= wrData[PIL_W-1:0];
      if (stb.wrPst) pstQ <= wrData;
      if (stb.wrTba) tbaQ <= wrData[DATA_W-1:TBA_LOW];
      if (stb.wrHst) hstQ <= wrData | ID_MASK;
    end
  end

  for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
    always_ff @(posedge clk) begin
      if (rst)             qReg[g] <= '0;
      else if (stb.wrQ[g]) qReg[g] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (!stb.rdNone) begin
      if (stb.rdSel[3]) begin
        rdData = qReg[stb.rdSel[2:0]];
      end else begin
        case (base_sel_e'(stb.rdSel[2:0]))
          SEL_SOFT, SEL_SSET, SEL_SCLR: rdData = DATA_W'(softQ);
          SEL_PIL: rdData = DATA_W'(pilQ);
          SEL_PST: rdData = pstQ;
          SEL_TBA: rdData = {tbaQ, {TBA_LOW{1'b0}}};
          SEL_VER: rdData = VER_WORD;
          SEL_HST: rdData = hstQ;
          default: rdData = '0;
        endcase
      end
    end
  end

  assign recheck = recheckQ;
endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file
  import ctlreg_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int SOFT_W  = 17,
  parameter int PIL_W   = 4,
  parameter int IE_BIT  = 1,
  parameter int ID_BIT  = 11,
  parameter int WINDOWS = 8,
  parameter int MAX_TL  = 6,
  parameter int MAX_GL  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              err,
  output logic              recheck
);
  strobe_t stb;

  ctlreg_ctrl u_ctrl (
    .accEn(accEn), .wrEn(wrEn), .addr(addr), .stb(stb), .err(err)
  );

  ctlreg_dpath #(
    .DATA_W(DATA_W), .SOFT_W(SOFT_W), .PIL_W(PIL_W), .IE_BIT(IE_BIT),
    .ID_BIT(ID_BIT), .TBA_LOW(15), .WINDOWS(WINDOWS), .MAX_TL(MAX_TL),
    .MAX_GL(MAX_GL)
  ) u_dpath (
    .clk(clk), .rst(rst), .stb(stb), .wrData(wrData),
    .rdData(rdData), .recheck(recheck)
  );
endmodule

// File: rtl/ctlreg_chk.sv
module ctlreg_chk #(
  parameter int DATA_W  = 64,
  parameter int ID_BIT  = 11,
  parameter int WINDOWS = 8,
  parameter int MAX_TL  = 6,
  parameter int MAX_GL  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              accEn,
  input logic              wrEn,
  input logic [4:0]        addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              err,
  input logic              recheck
);
  // R7: trap-base low bits read zero
  p_tba_low_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (accEn && addr == 5'd5) |-> rdData[14:0] == 15'd0);

  // R8: version read composition and refused writes
  p_ver_read_r8: assert property (@(posedge clk) disable iff (rst)
    (accEn && addr == 5'd6) |->
      (rdData[7:0] == 8'(WINDOWS) && rdData[15:8] == 8'(MAX_TL) &&
       rdData[23:16] == 8'(MAX_GL)));
  p_ver_write_err_r8: assert property (@(posedge clk) disable iff (rst)
    (accEn && wrEn && addr == 5'd6) |-> err);

  // R9: identification bit visible after a write
  p_hst_id_r9: assert property (@(posedge clk) disable iff (rst)
    (accEn && wrEn && addr == 5'd7) |=> (!(accEn && addr == 5'd7) || rdData[ID_BIT]));

  // R10: queue writes always pulse
  p_queue_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (accEn && wrEn && addr[4:3] == 2'b01) |=> recheck);

  // R11: unmapped access flags error and raises no pulse
  p_unmapped_err_r11: assert property (@(posedge clk) disable iff (rst)
    (accEn && addr[4]) |-> (err && rdData == '0));
  p_unmapped_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (accEn && wrEn && addr[4]) |=> !recheck);

  // R12: no pulse without a write in the previous cycle
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !(accEn && wrEn) |=> !recheck);
endmodule

bind ctlreg_file ctlreg_chk #(
  .DATA_W(DATA_W), .ID_BIT(ID_BIT), .WINDOWS(WINDOWS),
  .MAX_TL(MAX_TL), .MAX_GL(MAX_GL)
) u_chk (.*);

// File: tb/ctlreg_file_test.sv
`timescale 1ns/1ps
module ctlreg_file_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        accEn = 1'b0, wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic        err, recheck;
  int          checks = 0, fails = 0;

  localparam logic [63:0] VER = 64'h0003_0608;

  ctlreg_file uut (.*);

  always #4 clk = ~clk;

  typedef struct packed {
    logic [4:0]  a;
    logic [63:0] d;
    logic [4:0]  ca;
    logic [63:0] exp;
    logic        rc;
    logic        er;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{5'd0, 64'h5,        5'd0, 64'h5,     1'b1, 1'b0, 8'd2},   // R2 change
    '{5'd0, 64'h5,        5'd0, 64'h5,     1'b0, 1'b0, 8'd2},   // R2 same value
    '{5'd1, 64'h30,       5'd1, 64'h35,    1'b1, 1'b0, 8'd3},   // R3 set
    '{5'd1, 64'h1,        5'd0, 64'h35,    1'b0, 1'b0, 8'd3},   // R3 no change
    '{5'd2, 64'h14,       5'd2, 64'h21,    1'b1, 1'b0, 8'd4},   // R4 clear
    '{5'd2, 64'h2,        5'd0, 64'h21,    1'b0, 1'b0, 8'd4},   // R4 no change
    '{5'd0, 64'hFFFF_FFFF,5'd0, 64'h1FFFF, 1'b1, 1'b0, 8'd2},   // R2 truncation
    '{5'd3, 64'h9,        5'd3, 64'h9,     1'b0, 1'b0, 8'd5},   // R5 raise
    '{5'd3, 64'h1C,       5'd3, 64'hC,     1'b0, 1'b0, 8'd5},   // R5 truncation
    '{5'd3, 64'h3,        5'd3, 64'h3,     1'b1, 1'b0, 8'd5},   // R5 lower
    '{5'd3, 64'h3,        5'd3, 64'h3,     1'b0, 1'b0, 8'd5},   // R5 equal
    '{5'd4, 64'h2,        5'd4, 64'h2,     1'b1, 1'b0, 8'd6},   // R6 rise
    '{5'd4, 64'h6,        5'd4, 64'h6,     1'b0, 1'b0, 8'd6},   // R6 stays
    '{5'd4, 64'h4,        5'd4, 64'h4,     1'b0, 1'b0, 8'd6},   // R6 fall
    '{5'd4, 64'hA,        5'd4, 64'hA,     1'b1, 1'b0, 8'd6},   // R6 rise again
    '{5'd5, 64'hFFFF_FFFF_FFFF_FFFF, 5'd5, 64'hFFFF_FFFF_FFFF_8000, 1'b0, 1'b0, 8'd7}, // R7
    '{5'd7, 64'h0,        5'd7, 64'h800,   1'b0, 1'b0, 8'd9},   // R9
    '{5'd7, 64'h1234_0000,5'd7, 64'h1234_0800, 1'b0, 1'b0, 8'd9}, // R9
    '{5'd6, 64'hFF,       5'd6, VER,       1'b0, 1'b1, 8'd8},   // R8 write refused
    '{5'd8, 64'hAAAA,     5'd8, 64'hAAAA,  1'b1, 1'b0, 8'd10},  // R10 q0
    '{5'd15,64'h1,        5'd15,64'h1,     1'b1, 1'b0, 8'd10},  // R10 q7
    '{5'd11,64'h0,        5'd11,64'h0,     1'b1, 1'b0, 8'd10},  // R10 unchanged still pulses
    '{5'd20,64'hFFFF,     5'd8, 64'hAAAA,  1'b0, 1'b1, 8'd11}   // R11 unmapped write
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [4:0] a, input logic [63:0] d, output logic e);
    @(negedge clk);
    accEn = 1'b1; wrEn = 1'b1; addr = a; wrData = d;
    #1 e = err;
    @(posedge clk);
    #1 accEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [4:0] a, output logic [63:0] v, output logic e);
    accEn = 1'b1; wrEn = 1'b0; addr = a;
    #1 v = rdData; e = err;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    logic e;
    logic [63:0] v;
    doReset();

    // R1: reset state
    check("R1 recheck", 64'(recheck), 64'h0);
    for (int a = 0; a < 16; a++) begin
      doRead(5'(a), v, e);
      check("R1 reset read", v, (a == 6) ? VER : 64'h0);
    end
    accEn = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      doWrite(VECS[i].a, VECS[i].d, e);
      check({tag, " err"}, 64'(e), 64'(VECS[i].er));
      check({tag, " recheck"}, 64'(recheck), 64'(VECS[i].rc));
      doRead(VECS[i].ca, v, e);
      check({tag, " read"}, v, VECS[i].exp);
      accEn = 1'b0;
    end

    // R11: unmapped read flags error and returns zero
    @(negedge clk);
    doRead(5'd31, v, e);
    check("R11 unmapped err", 64'(e), 64'h1);
    check("R11 unmapped data", v, 64'h0);
    accEn = 1'b0;

    // R12: pulse lasts exactly one cycle
    doWrite(5'd9, 64'h77, e);
    check("R12 pulse high", 64'(recheck), 64'h1);
    @(posedge clk); #1;
    check("R12 pulse low", 64'(recheck), 64'h0);

    // R8: write to version did not change other state; version read is plain
    @(negedge clk);
    doRead(5'd6, v, e);
    check("R8 version read err", 64'(e), 64'h0);
    check("R8 version word", v, VER);
    accEn = 1'b0;

    // R1: reset clears written state
    doReset();
    doRead(5'd8, v, e);
    check("R1 queue after reset", v, 64'h0);
    doRead(5'd0, v, e);
    check("R1 soft after reset", v, 64'h0);
    doRead(5'd7, v, e);
    check("R1 hstate after reset", v, 64'h0);
    accEn = 1'b0;

    finishRun();
  end
endmodule